// File: doc/BRIEF.md
# Serial Debug Register Access Port

This block is the serial front end between a test access port controller and a small bank of debug registers. The controller provides a test clock, an active-low asynchronous reset and three strobes: capture, shift and update. Each access uses one 38-bit frame. The frame holds a 32-bit data word, a 5-bit register address and a direction flag. The frame enters on the serial input least significant bit first and leaves on the serial output in the same order.

An access commits only on the update strobe. With the direction flag set, the data word is written into the addressed register. With the flag clear, the addressed register is selected for read-back. The next capture strobe then loads the value of the selected register into the frame, so it can be shifted out.

The registers are:
- a debug control word,
- a debug status word,
- a communications control word,
- a communications data word,
- two watchpoint sets of six registers each.

The registers have different widths. Every register value is brought out as a port, for the comparator logic next to this block.

Top module: `dbgScanPort`

## Requirements
- R1: While trstN is low, every register output is zero and the shift frame is zero, so tdo is 0.
- R2: Each cycle with shiftDr high (and updateDr and captureDr low) moves the frame one place toward bit 0. tdi enters bit 37 and tdo always shows bit 0, so a frame leaves in the order it arrived.
- R3: Frame bits 31:0 are the data word, bits 36:32 the register address and bit 37 the direction flag. On updateDr with bit 37 = 1, the data word is written into the register at that address.
- R4: No register changes on a cycle without updateDr, even when a complete write frame has been shifted in.
- R5: On updateDr with bit 37 = 0, no register changes, whatever the data word holds. Only the read selection moves to the frame's address.
- R6: On captureDr, the frame is loaded as follows: bits 31:0 take the selected register zero-extended, bits 36:32 take the selected address, and bit 37 takes 0. The selection after reset is address 00000.
- R7: The widths are debug control 3 bits at 00000, debug status 5 bits at 00001, communications control 6 bits at 00100 and communications data 32 bits at 00101. A write keeps only the low bits up to the width, and read-back is zero-extended.
- R8: A write to an unmapped address changes no register, and a read of an unmapped address returns zero.
- R9: Watchpoint 0 occupies 01000 to 01101 and watchpoint 1 occupies 10000 to 10101. In each, offsets 0 to 5 are address value, address mask, data value, data mask, control value and control mask. The control value is 9 bits wide, the control mask 8 bits and the rest 32 bits.
- R10: A write to the register that is currently selected for read-back leaves the selection in place. The next captureDr returns the new value.
- R11: If updateDr is high together with captureDr or shiftDr, only the update acts and the frame is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| captureDr | input | 1 | Capture strobe, loads read-back into the frame |
| shiftDr | input | 1 | Shift strobe, one bit per cycle |
| updateDr | input | 1 | Update strobe, commits the frame |
| tdo | output | 1 | Serial data out (frame bit 0) |
| dbgCtrl | output | 3 | Debug control register |
| dbgStatus | output | 5 | Debug status register |
| commCtrl | output | 6 | Communications control register |
| commData | output | 32 | Communications data register |
| wpAddrVal | output | 64 | Address value, watchpoint n in bits 32n+31:32n |
| wpAddrMask | output | 64 | Address mask, watchpoint n in bits 32n+31:32n |
| wpDataVal | output | 64 | Data value, watchpoint n in bits 32n+31:32n |
| wpDataMask | output | 64 | Data mask, watchpoint n in bits 32n+31:32n |
| wpCtrlVal | output | 18 | Control value, watchpoint n in bits 9n+8:9n |
| wpCtrlMask | output | 16 | Control mask, watchpoint n in bits 8n+7:8n |

## Verification
A write commit can land on the very register that an earlier read frame selected. This is the one place where register storage and the read-selection path meet in a single update.

The bench provokes it in three steps:
1. It selects the communications data register with a read frame.
2. It commits a write of a new word to that same address.
3. It issues a capture without any new read frame.

The check passes only if the shifted-out frame carries the new word and still names the communications data address. A stale word, or a selection moved by the write, both fail it.

// File: rtl/dbgScanPkg.sv
package dbgScanPkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int NUM_WP = 2;

  localparam int DBG_CTRL_W  = 3;
  localparam int DBG_STAT_W  = 5;
  localparam int COMM_CTRL_W = 6;
  localparam int WP_CVAL_W   = 9;
  localparam int WP_CMASK_W  = 8;

  localparam logic [4:0] ADR_DBG_CTRL  = 5'b00000;
  localparam logic [4:0] ADR_DBG_STAT  = 5'b00001;
  localparam logic [4:0] ADR_COMM_CTRL = 5'b00100;
  localparam logic [4:0] ADR_COMM_DATA = 5'b00101;

  localparam logic [2:0] OFF_ADDR_VAL  = 3'd0;
  localparam logic [2:0] OFF_ADDR_MASK = 3'd1;
  localparam logic [2:0] OFF_DATA_VAL  = 3'd2;
  localparam logic [2:0] OFF_DATA_MASK = 3'd3;
  localparam logic [2:0] OFF_CTRL_VAL  = 3'd4;
  localparam logic [2:0] OFF_CTRL_MASK = 3'd5;

  typedef struct packed {
    logic commit;
    logic load;
    logic shift;
  } scanStrobe_t;

endpackage

// File: rtl/dbgScanCtrl.sv
module dbgScanCtrl
  import dbgScanPkg::*;
(
  input  logic        captureDr,
  input  logic        shiftDr,
  input  logic        updateDr,
  output scanStrobe_t stb
);

  // Update wins over capture, capture wins over shift.
  always_comb begin
    stb.commit = updateDr;
    stb.load   = captureDr && !updateDr;
    stb.shift  = shiftDr && !captureDr && !updateDr;
  end

endmodule

// File: rtl/dbgScanData.sv
module dbgScanData
  import dbgScanPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NW = NUM_WP
) (
  input  logic                  tck,
  input  logic                  trstN,
  input  logic                  tdi,
  input  scanStrobe_t           stb,
  output logic                  tdo,
  output logic [DBG_CTRL_W-1:0] dbgCtrl,
  output logic [DBG_STAT_W-1:0] dbgStatus,
  output logic [COMM_CTRL_W-1:0] commCtrl,
  output logic [DW-1:0]         commData,
  output logic [NW*DW-1:0]      wpAddrVal,
  output logic [NW*DW-1:0]      wpAddrMask,
  output logic [NW*DW-1:0]      wpDataVal,
  output logic [NW*DW-1:0]      wpDataMask,
  output logic [NW*WP_CVAL_W-1:0]  wpCtrlVal,
  output logic [NW*WP_CMASK_W-1:0] wpCtrlMask
);

  localparam int FRAME_W  = DW + AW + 1;
  localparam int FLAG_POS = FRAME_W - 1;
  localparam int OFF_W    = 3;

  logic [FRAME_W-1:0] frame;
  logic [AW-1:0]      readSel;
  logic [DW-1:0]      rdData;

  logic          frameWrite;
  logic [AW-1:0] frameAddr;
  logic [DW-1:0] frameData;
  logic          wrEn;

  assign frameWrite = frame[FLAG_POS];
  assign frameAddr  = frame[DW +: AW];
  assign frameData  = frame[DW-1:0];
  assign wrEn       = stb.commit && frameWrite;
  assign tdo        = frame[0];

  // Shift frame: capture load or serial shift; untouched on commit.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      frame <= '0;
    end else if (stb.load) begin
      frame <= {1'b0, readSel, rdData};
    end else if (stb.shift) begin
      frame <= {tdi, frame[FRAME_W-1:1]};
    end
  end

  // Read selection moves only on a read commit.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      readSel <= '0;
    end else if (stb.commit && !frameWrite) begin
      readSel <= frameAddr;
    end
  end

  // Debug and communications registers.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      dbgCtrl   <= '0;
      dbgStatus <= '0;
      commCtrl  <= '0;
      commData  <= '0;
    end else if (wrEn) begin
      if (frameAddr == AW'(ADR_DBG_CTRL))  dbgCtrl   <= frameData[DBG_CTRL_W-1:0];
      if (frameAddr == AW'(ADR_DBG_STAT))  dbgStatus <= frameData[DBG_STAT_W-1:0];
      if (frameAddr == AW'(ADR_COMM_CTRL)) commCtrl  <= frameData[COMM_CTRL_W-1:0];
      if (frameAddr == AW'(ADR_COMM_DATA)) commData  <= frameData;
    end
  end

  logic [DW-1:0] wpRd [NW];

  // One register set per watchpoint, each set on its own 8-address block.
  for (genvar w = 0; w < NW; w++) begin : g_wp
    localparam logic [AW-1:0] BASE = AW'((w + 1) * 8);
    logic [DW-1:0]          av, am, dv, dm;
    logic [WP_CVAL_W-1:0]   cv;
    logic [WP_CMASK_W-1:0]  cm;
    logic                   wrHit, rdHit;

    assign wrHit = wrEn && (frameAddr[AW-1:OFF_W] == BASE[AW-1:OFF_W]);
    assign rdHit = (readSel[AW-1:OFF_W] == BASE[AW-1:OFF_W]);

    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN) begin
        av <= '0; am <= '0; dv <= '0; dm <= '0; cv <= '0; cm <= '0;
      end else if (wrHit) begin
        case (frameAddr[OFF_W-1:0])
          OFF_ADDR_VAL:  av <= frameData;
          OFF_ADDR_MASK: am <= frameData;
          OFF_DATA_VAL:  dv <= frameData;
          OFF_DATA_MASK: dm <= frameData;
          OFF_CTRL_VAL:  cv <= frameData[WP_CVAL_W-1:0];
          OFF_CTRL_MASK: cm <= frameData[WP_CMASK_W-1:0];
          default: ;
        endcase
      end
    end

    always_comb begin
      wpRd[w] = '0;
      if (rdHit) begin
        case (readSel[OFF_W-1:0])
          OFF_ADDR_VAL:  wpRd[w] = av;
          OFF_ADDR_MASK: wpRd[w] = am;
          OFF_DATA_VAL:  wpRd[w] = dv;
          OFF_DATA_MASK: wpRd[w] = dm;
          OFF_CTRL_VAL:  wpRd[w] = DW'(cv);
          OFF_CTRL_MASK: wpRd[w] = DW'(cm);
          default:       wpRd[w] = '0;
        endcase
      end
    end

    assign wpAddrVal[w*DW +: DW]                  = av;
    assign wpAddrMask[w*DW +: DW]                 = am;
    assign wpDataVal[w*DW +: DW]                  = dv;
    assign wpDataMask[w*DW +: DW]                 = dm;
    assign wpCtrlVal[w*WP_CVAL_W +: WP_CVAL_W]    = cv;
    assign wpCtrlMask[w*WP_CMASK_W +: WP_CMASK_W] = cm;
  end

  // Read-back multiplexer, zero for unmapped addresses.
  always_comb begin
    rdData = '0;
    case (readSel)
      AW'(ADR_DBG_CTRL):  rdData = DW'(dbgCtrl);
      AW'(ADR_DBG_STAT):  rdData = DW'(dbgStatus);
      AW'(ADR_COMM_CTRL): rdData = DW'(commCtrl);
      AW'(ADR_COMM_DATA): rdData = commData;
      default:            rdData = '0;
    endcase
    for (int w = 0; w < NW; w++) rdData = rdData | wpRd[w];
  end

  // Assertions
  p_shift_order_r2: assert property (@(posedge tck) disable iff (!trstN)
    stb.shift |=> (frame[FLAG_POS] == $past(tdi)) && (tdo == $past(frame[1])));

  p_hold_no_update_r4: assert property (@(posedge tck) disable iff (!trstN)
    !stb.commit |=> $stable(dbgCtrl) && $stable(dbgStatus) && $stable(commCtrl) &&
                    $stable(commData) && $stable(wpAddrVal) && $stable(wpAddrMask) &&
                    $stable(wpDataVal) && $stable(wpDataMask) && $stable(wpCtrlVal) &&
                    $stable(wpCtrlMask));

  p_read_no_write_r5: assert property (@(posedge tck) disable iff (!trstN)
    (stb.commit && !frameWrite) |=> $stable(commData) && $stable(wpAddrVal) &&
                    $stable(wpDataMask) && $stable(dbgCtrl) && $stable(wpCtrlVal));

  p_capture_comm_r6: assert property (@(posedge tck) disable iff (!trstN)
    (stb.load && readSel == AW'(ADR_COMM_DATA)) |=>
      (frameData == commData) && !frameWrite && (frameAddr == AW'(ADR_COMM_DATA)));

  p_zero_extend_r7: assert property (@(posedge tck) disable iff (!trstN)
    (stb.load && readSel == AW'(ADR_DBG_CTRL)) |=> (frameData[DW-1:DBG_CTRL_W] == '0));

  p_unmapped_zero_r8: assert property (@(posedge tck) disable iff (!trstN)
    (stb.load && readSel == AW'(5'b00010)) |=> (frameData == '0));

  p_update_keeps_frame_r11: assert property (@(posedge tck) disable iff (!trstN)
    stb.commit |=> $stable(frame));

endmodule

// File: rtl/dbgScanPort.sv
module dbgScanPort
  import dbgScanPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NW = NUM_WP
) (
  input  logic                     tck,
  input  logic                     trstN,
  input  logic                     tdi,
  input  logic                     captureDr,
  input  logic                     shiftDr,
  input  logic                     updateDr,
  output logic                     tdo,
  output logic [DBG_CTRL_W-1:0]    dbgCtrl,
  output logic [DBG_STAT_W-1:0]    dbgStatus,
  output logic [COMM_CTRL_W-1:0]   commCtrl,
  output logic [DW-1:0]            commData,
  output logic [NW*DW-1:0]         wpAddrVal,
  output logic [NW*DW-1:0]         wpAddrMask,
  output logic [NW*DW-1:0]         wpDataVal,
  output logic [NW*DW-1:0]         wpDataMask,
  output logic [NW*WP_CVAL_W-1:0]  wpCtrlVal,
  output logic [NW*WP_CMASK_W-1:0] wpCtrlMask
);

  scanStrobe_t stb;

  dbgScanCtrl u_ctrl (
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .stb       (stb)
  );

  dbgScanData #(.DW(DW), .AW(AW), .NW(NW)) u_data (
    .tck        (tck),
    .trstN      (trstN),
    .tdi        (tdi),
    .stb        (stb),
    .tdo        (tdo),
    .dbgCtrl    (dbgCtrl),
    .dbgStatus  (dbgStatus),
    .commCtrl   (commCtrl),
    .commData   (commData),
    .wpAddrVal  (wpAddrVal),
    .wpAddrMask (wpAddrMask),
    .wpDataVal  (wpDataVal),
    .wpDataMask (wpDataMask),
    .wpCtrlVal  (wpCtrlVal),
    .wpCtrlMask (wpCtrlMask)
  );

endmodule

// File: tb/tb_dbgScanPort.sv
`timescale 1ns/1ps
module tb_dbgScanPort;

  logic tck = 0, trstN = 0, tdi = 0, captureDr = 0, shiftDr = 0, updateDr = 0;
  logic tdo;
  logic [2:0] dbgCtrl; logic [4:0] dbgStatus; logic [5:0] commCtrl; logic [31:0] commData;
  logic [63:0] wpAddrVal, wpAddrMask, wpDataVal, wpDataMask;
  logic [17:0] wpCtrlVal; logic [15:0] wpCtrlMask;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 tck = ~tck;

  dbgScanPort dut (
    .tck(tck), .trstN(trstN), .tdi(tdi), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdo(tdo), .dbgCtrl(dbgCtrl), .dbgStatus(dbgStatus),
    .commCtrl(commCtrl), .commData(commData), .wpAddrVal(wpAddrVal),
    .wpAddrMask(wpAddrMask), .wpDataVal(wpDataVal), .wpDataMask(wpDataMask),
    .wpCtrlVal(wpCtrlVal), .wpCtrlMask(wpCtrlMask)
  );

  function automatic logic [399:0] snap();
    return {46'd0, dbgCtrl, dbgStatus, commCtrl, commData, wpAddrVal, wpAddrMask,
            wpDataVal, wpDataMask, wpCtrlVal, wpCtrlMask};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shiftFrame(input logic [37:0] f, output logic [37:0] got, input bit doUpd);
    for (int i = 0; i < 38; i++) begin
      @(negedge tck); shiftDr = 1; tdi = f[i];
      #1 got[i] = tdo;
    end
    @(negedge tck); shiftDr = 0; tdi = 0; updateDr = doUpd;
    @(negedge tck); updateDr = 0;
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d);
    logic [37:0] g;
    shiftFrame({1'b1, a, d}, g, 1);
  endtask

  task automatic capture();
    @(negedge tck); captureDr = 1;
    @(negedge tck); captureDr = 0;
  endtask

  task automatic readReg(input logic [4:0] a, output logic [37:0] got);
    logic [37:0] g;
    shiftFrame({1'b0, a, 32'h0}, g, 1);
    capture();
    shiftFrame(38'd0, got, 0);
  endtask

  task automatic tReset();
    chk("R1 tdo", {63'd0, tdo}, 64'd0);
    chk("R1 regs", snap() == 400'd0 ? 64'd1 : 64'd0, 64'd1);
  endtask

  task automatic tWriteRead();
    logic [37:0] g;
    writeReg(5'b00101, 32'hA5A5_5A5A);
    chk("R3 commData", commData, 32'hA5A5_5A5A);
    readReg(5'b00101, g);
    chk("R6 data field", g[31:0], 32'hA5A5_5A5A);
    chk("R6 addr and flag", g[37:32], {1'b0, 5'b00101});
  endtask

  task automatic tWidths();
    logic [37:0] g;
    writeReg(5'b00000, 32'hFFFF_FFFF);
    writeReg(5'b00001, 32'hFFFF_FFFF);
    writeReg(5'b00100, 32'hFFFF_FFFF);
    chk("R7 dbgCtrl", dbgCtrl, 3'h7);
    chk("R7 dbgStatus", dbgStatus, 5'h1F);
    chk("R7 commCtrl", commCtrl, 6'h3F);
    readReg(5'b00000, g); chk("R7 read ctrl", g[31:0], 32'h7);
    readReg(5'b00001, g); chk("R7 read status", g[31:0], 32'h1F);
    readReg(5'b00100, g); chk("R7 read commCtrl", g[31:0], 32'h3F);
  endtask

  task automatic tWatchpoints();
    logic [37:0] g;
    writeReg(5'b01000, 32'h1111_1111); writeReg(5'b01001, 32'h2222_2222);
    writeReg(5'b01010, 32'h3333_3333); writeReg(5'b01011, 32'h4444_4444);
    writeReg(5'b01100, 32'hFFFF_FF55); writeReg(5'b01101, 32'hFFFF_FFAA);
    writeReg(5'b10000, 32'h5555_5555); writeReg(5'b10001, 32'h6666_6666);
    writeReg(5'b10010, 32'h7777_7777); writeReg(5'b10011, 32'h8888_8888);
    writeReg(5'b10100, 32'h0000_00CA); writeReg(5'b10101, 32'h0000_015C);
    chk("R9 addr val", wpAddrVal, 64'h5555_5555_1111_1111);
    chk("R9 addr mask", wpAddrMask, 64'h6666_6666_2222_2222);
    chk("R9 data val", wpDataVal, 64'h7777_7777_3333_3333);
    chk("R9 data mask", wpDataMask, 64'h8888_8888_4444_4444);
    chk("R9 ctrl val", wpCtrlVal, {9'h0CA, 9'h155});
    chk("R9 ctrl mask", wpCtrlMask, {8'h5C, 8'hAA});
    readReg(5'b01100, g); chk("R9 read wp0 ctrl val", g[31:0], 32'h155);
    readReg(5'b10011, g); chk("R9 read wp1 data mask", g[31:0], 32'h8888_8888);
  endtask

  task automatic tUnmapped();
    logic [399:0] s;
    logic [37:0] g;
    s = snap();
    writeReg(5'b00010, 32'hFFFF_FFFF); writeReg(5'b00110, 32'hFFFF_FFFF);
    writeReg(5'b01110, 32'hFFFF_FFFF); writeReg(5'b11000, 32'hFFFF_FFFF);
    chk("R8 writes discarded", snap() == s ? 64'd1 : 64'd0, 64'd1);
    readReg(5'b00010, g); chk("R8 read 00010", g[31:0], 32'h0);
    readReg(5'b11101, g); chk("R8 read 11101", g[31:0], 32'h0);
  endtask

  task automatic tReadIgnoresData();
    logic [399:0] s;
    logic [37:0] g;
    s = snap();
    shiftFrame({1'b0, 5'b00101, 32'hDEAD_BEEF}, g, 1);
    chk("R5 read leaves regs", snap() == s ? 64'd1 : 64'd0, 64'd1);
    chk("R5 commData", commData, 32'hA5A5_5A5A);
  endtask

  task automatic tNoUpdate();
    logic [399:0] s;
    logic [37:0] g, g2;
    s = snap();
    shiftFrame({1'b1, 5'b00101, 32'h1234_5678}, g, 0);
    repeat (3) @(negedge tck);
    chk("R4 no commit", snap() == s ? 64'd1 : 64'd0, 64'd1);
    shiftFrame(38'd0, g2, 0);
    chk("R2 frame out", {26'd0, g2}, {26'd0, 1'b1, 5'b00101, 32'h1234_5678});
  endtask

  task automatic tWriteSelected();
    logic [37:0] g;
    shiftFrame({1'b0, 5'b00101, 32'h0}, g, 1);
    writeReg(5'b00101, 32'hC0DE_0F0F);
    capture();
    shiftFrame(38'd0, g, 0);
    chk("R10 new value", g[31:0], 32'hC0DE_0F0F);
    chk("R10 selection kept", g[37:32], {1'b0, 5'b00101});
  endtask

  task automatic tPriority();
    logic [37:0] g, g2;
    // frame now holds zero after the last shift; load a write frame, no update yet
    shiftFrame({1'b1, 5'b00101, 32'h0BAD_F00D}, g, 0);
    @(negedge tck); updateDr = 1; shiftDr = 1; captureDr = 1; tdi = 0;
    @(negedge tck); updateDr = 0; shiftDr = 0; captureDr = 0;
    chk("R11 update acted", commData, 32'h0BAD_F00D);
    shiftFrame(38'd0, g2, 0);
    chk("R11 frame unaltered", {26'd0, g2}, {26'd0, 1'b1, 5'b00101, 32'h0BAD_F00D});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge tck);
    tReset();
    trstN = 1;
    @(negedge tck);
    tWriteRead();
    tWidths();
    tWatchpoints();
    tUnmapped();
    tReadIgnoresData();
    tNoUpdate();
    tWriteSelected();
    tPriority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule